// File: doc/BRIEF.md
# PWM Gate Control Core with Blanking and Brown-out Supervision

This block is the digital heart of a fixed-frequency, current-mode PWM converter stage. A free-running period counter starts every switching cycle by setting a gate latch. The on-time ends at the first clear request, and the gate output falls in that same cycle. A clear request comes from the control-loop comparator, from the duty limit, or from the peak-current comparator. The current flag is masked for a short window after every turn-on, so that the switching spike cannot cut the pulse short.

Two comparator flags watch the bus. One means the bus has sagged and the other means it has recovered. Each flag must hold steady for a qualification time before it changes the bus state, and the gap between the two thresholds gives hysteresis. The gate is held off while the bus is marked down and while the supply undervoltage flag is set. Leaving either condition, and leaving reset, restarts a soft-start ramp. The ramp raises the duty limit in equal steps over a set number of periods until it reaches the maximum on-time.

Top module: `gate_pwm_ctrl`

## Requirements
- R1: Turn-on happens only at the first cycle of a switching period (period counter value 0), and periods are exactly PERIOD_CYC clock cycles long.
- R2: In steady state with no clear request, the gate stays high for exactly MAX_ON_CYC cycles per period (period counter values 0 to MAX_ON_CYC-1).
- R3: A high `loop_cmp_i` in period cycle k (k>=1) drives `gate_o` low in that same cycle. The gate stays low for the rest of the period, even after the flag drops, so the on-time is k cycles.
- R4: A high `ilim_i` in period cycle k, with k>=BLANK_CYC, ends the on-time in that same cycle just as R3 does. The following period runs at its normal on-time.
- R5: `ilim_i` has no effect in period cycles 0 to BLANK_CYC-1. `loop_cmp_i` is never blanked.
- R6: While the bus is up, `bus_low_i` must be high for FILT_CYC consecutive cycles to mark the bus down and stop the gate. A run of FILT_CYC-1 cycles changes nothing.
- R7: While the bus is down, only `bus_high_i` held for FILT_CYC consecutive cycles marks it up again. Both flags low for any length of time, or a shorter `bus_high_i` run, keeps the gate off.
- R8: After reset, after bus recovery and after undervoltage release, the on-time of the n-th pulse is floor(MAX_ON_CYC*n/SS_STEPS) for n=1..SS_STEPS. After that it is MAX_ON_CYC.
- R9: A high `uvlo_i` drives `gate_o` low in the same cycle, keeps it low, and resets the soft-start ramp.
- R10: During reset and after it, `gate_o` is low until the bus has been qualified up through R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_cmp_i | input | 1 | Control-loop comparator: ramp reached error level |
| ilim_i | input | 1 | Peak current comparator: sense above limit |
| bus_low_i | input | 1 | Bus sense below lower threshold |
| bus_high_i | input | 1 | Bus sense above upper threshold |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| gate_o | output | 1 | Gate drive enable, active high |

## Verification
The bench places single-cycle comparator pulses at chosen period offsets. A current pulse just inside the blanking window and one exactly at its edge tell a miscounted window apart. A latch that does not hold its cleared state, or a clear that acts one cycle late, shows up as an on-time off by one or reaching the full width. Brown-out flag runs one cycle short of the qualification time catch an off-by-one filter. A long stretch with both bus flags low catches a design without hysteresis. Restarts after brown-out and after undervoltage must show the first ramp step again, which a design that keeps its old duty would fail.

// File: rtl/gate_pwm_pkg.sv
`timescale 1ns/1ps
package gate_pwm_pkg;

  typedef enum logic {
    BUS_DOWN = 1'b0,
    BUS_UP   = 1'b1
  } bus_state_e;

  // On-time limit for ramp step 'step' of 'steps'
  function automatic int ramp_limit(input int max_on, input int steps, input int step);
    return (max_on * step) / steps;
  endfunction

endpackage

// File: rtl/pwm_period_timer.sv
`timescale 1ns/1ps
module pwm_period_timer #(
  parameter int PERIOD_CYC = 769,
  localparam int CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == CW'(PERIOD_CYC - 1));

  always_comb begin
    if (last_o) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_bo_filter.sv
`timescale 1ns/1ps
module pwm_bo_filter
  import gate_pwm_pkg::*;
#(
  parameter int FILT_CYC = 5000,
  localparam int FW = $clog2(FILT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_i,
  input  logic high_i,
  output logic bus_ok_o
);

  bus_state_e    st_q, st_d;
  logic [FW-1:0] run_q, run_d;
  logic          toward;

  // The flag that would move the state away from where it is
  assign toward = (st_q == BUS_UP) ? low_i : high_i;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (!toward) begin
      run_d = '0;
    end else if (run_q == FW'(FILT_CYC - 1)) begin
      run_d = '0;
      st_d  = (st_q == BUS_UP) ? BUS_DOWN : BUS_UP;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BUS_DOWN;
      run_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign bus_ok_o = (st_q == BUS_UP);

endmodule

// File: rtl/pwm_soft_start.sv
`timescale 1ns/1ps
module pwm_soft_start
  import gate_pwm_pkg::*;
#(
  parameter int MAX_ON_CYC = 361,
  parameter int SS_STEPS   = 64,
  parameter int CW         = 10,
  localparam int SW = $clog2(SS_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          period_end_i,
  output logic [CW-1:0] lim_o
);

  logic [SW-1:0] step_q, step_d;
  logic          step_en;

  assign step_en = run_i && period_end_i && (step_q != SW'(SS_STEPS));

  always_comb begin
    if (!run_i)       step_d = '0;
    else if (step_en) step_d = step_q + 1'b1;
    else              step_d = step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign lim_o = CW'(ramp_limit(MAX_ON_CYC, SS_STEPS, int'(step_q)));

endmodule

// File: rtl/pwm_gate_chk.sv
`timescale 1ns/1ps
module pwm_gate_chk #(
  parameter int PERIOD_CYC = 769,
  parameter int MAX_ON_CYC = 361,
  parameter int CW         = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uvlo_i,
  input logic          gate_o,
  input logic          bus_ok,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim
);

  p_turn_on_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (cnt == '0));

  p_on_time_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> (cnt < CW'(MAX_ON_CYC)));

  p_stays_off_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_o && (cnt != CW'(PERIOD_CYC - 1))) |=> !gate_o);

  p_bus_down_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok |-> !gate_o);

  p_restart_from_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ok) |-> (lim == '0));

  p_uvlo_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |-> !gate_o);

endmodule

// File: rtl/gate_pwm_ctrl.sv
`timescale 1ns/1ps
module gate_pwm_ctrl #(
  parameter int PERIOD_CYC = 769,
  parameter int MAX_ON_CYC = 361,
  parameter int BLANK_CYC  = 22,
  parameter int FILT_CYC   = 5000,
  parameter int SS_STEPS   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_cmp_i,
  input  logic ilim_i,
  input  logic bus_low_i,
  input  logic bus_high_i,
  input  logic uvlo_i,
  output logic gate_o
);

  localparam int CW = $clog2(PERIOD_CYC);

  logic          rst_meta, rst_sync_n;
  logic [CW-1:0] cnt;
  logic          last;
  logic          bus_ok;
  logic          run_ok;
  logic [CW-1:0] lim;
  logic          blank;
  logic          kill;
  logic          latch_q, latch_d;

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pwm_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cnt_o  (cnt),
    .last_o (last)
  );

  pwm_bo_filter #(.FILT_CYC(FILT_CYC)) u_bo (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .low_i    (bus_low_i),
    .high_i   (bus_high_i),
    .bus_ok_o (bus_ok)
  );

  assign run_ok = bus_ok && !uvlo_i;

  pwm_soft_start #(
    .MAX_ON_CYC (MAX_ON_CYC),
    .SS_STEPS   (SS_STEPS),
    .CW         (CW)
  ) u_ss (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .run_i        (run_ok),
    .period_end_i (last),
    .lim_o        (lim)
  );

  // Turn-on is always at cnt==0, so the blanking window follows the counter
  assign blank = (cnt < CW'(BLANK_CYC));

  assign kill = loop_cmp_i
             || (ilim_i && !blank)
             || (cnt >= lim)
             || !run_ok;

  always_comb begin
    if (last)      latch_d = run_ok;
    else if (kill) latch_d = 1'b0;
    else           latch_d = latch_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) latch_q <= 1'b0;
    else             latch_q <= latch_d;
  end

  // Clear acts in the same cycle, ahead of the latch register
  assign gate_o = latch_q && !kill;

endmodule

bind gate_pwm_ctrl pwm_gate_chk #(
  .PERIOD_CYC (PERIOD_CYC),
  .MAX_ON_CYC (MAX_ON_CYC),
  .CW         (CW)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .uvlo_i (uvlo_i),
  .gate_o (gate_o),
  .bus_ok (bus_ok),
  .cnt    (cnt),
  .lim    (lim)
);

// File: tb/gate_pwm_ctrl_test.sv
`timescale 1ns/1ps
module gate_pwm_ctrl_test;

  localparam int P  = 40;
  localparam int MX = 18;
  localparam int BL = 4;
  localparam int FL = 20;
  localparam int SS = 4;
  localparam int NONE = 63;
  localparam int NV = 10;

  // {loop_cmp offset, ilim offset, expected on-time}
  localparam int VEC [NV][3] = '{
    '{NONE, NONE, 18},
    '{10,   NONE, 10},
    '{NONE, 8,    8 },
    '{NONE, 2,    18},
    '{NONE, 3,    18},
    '{NONE, 4,    4 },
    '{5,    12,   5 },
    '{14,   6,    6 },
    '{NONE, 17,   17},
    '{1,    NONE, 1 }
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_cmp = 1'b0, ilim = 1'b0, bus_low = 1'b0, bus_high = 1'b0, uvlo = 1'b0;
  logic gate;
  logic last_g = 1'b0;
  int   n_chk = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  gate_pwm_ctrl #(
    .PERIOD_CYC (P),
    .MAX_ON_CYC (MX),
    .BLANK_CYC  (BL),
    .FILT_CYC   (FL),
    .SS_STEPS   (SS)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_cmp_i (loop_cmp),
    .ilim_i     (ilim),
    .bus_low_i  (bus_low),
    .bus_high_i (bus_high),
    .uvlo_i     (uvlo),
    .gate_o     (gate)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait for the next turn-on (or give up), then count high cycles over one period,
  // pulsing loop_cmp at offset a and ilim at offset b for one cycle each.
  task automatic measure(input int a, input int b, output int w);
    bit found = 0;
    w = 0;
    for (int i = 0; i < 3 * P && !found; i++) begin
      @(negedge clk); #1;
      if (gate && !last_g) found = 1;
      last_g = gate;
    end
    if (!found) return;
    w = 1;
    for (int k = 1; k < P; k++) begin
      @(negedge clk);
      loop_cmp = (k == a);
      ilim     = (k == b);
      #1;
      if (gate) w++;
      last_g = gate;
    end
    loop_cmp = 1'b0;
    ilim     = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int w;
    int highs;
    int c;

    // R10: reset state
    repeat (3) @(negedge clk);
    #1 check("R10 gate in reset", int'(gate), 0);
    rst_n = 1'b1;
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (gate) highs++;
    end
    check("R10 no gate before bus qualified", highs, 0);

    // R8: power-up ramp
    bus_high = 1'b1;
    measure(NONE, NONE, w); check("R8 ramp step 1", w, 4);
    measure(NONE, NONE, w); check("R8 ramp step 2", w, 9);
    measure(NONE, NONE, w); check("R8 ramp step 3", w, 13);
    measure(NONE, NONE, w); check("R8 ramp done R2", w, MX);

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NV; v++) begin
      measure(VEC[v][0], VEC[v][1], w);
      check($sformatf("R2 R3 R4 R5 vector %0d", v), w, VEC[v][2]);
    end
    measure(NONE, NONE, w); check("R4 next period full", w, MX);

    // R1: period length between turn-ons
    c = 0;
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk); #1;
      c++;
      if (gate && !last_g) break;
      last_g = gate;
    end
    last_g = gate;
    c = 0;
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk); #1;
      c++;
      if (gate && !last_g) begin last_g = gate; break; end
      last_g = gate;
    end
    check("R1 period length", c, P);

    // R6: short bus_low run ignored, long one stops gating
    bus_high = 1'b0;
    @(negedge clk);
    bus_low = 1'b1;
    repeat (FL - 1) @(negedge clk);
    bus_low = 1'b0;
    last_g = 1'b1;
    measure(NONE, NONE, w); check("R6 short low run ignored", w, MX);
    @(negedge clk);
    bus_low = 1'b1;
    repeat (FL + 5) @(negedge clk);
    measure(NONE, NONE, w); check("R6 bus down stops gate", w, 0);

    // R7: hysteresis band and short high run
    bus_low = 1'b0;
    repeat (200) @(negedge clk);
    measure(NONE, NONE, w); check("R7 both flags low keeps off", w, 0);
    bus_high = 1'b1;
    repeat (FL - 1) @(negedge clk);
    bus_high = 1'b0;
    measure(NONE, NONE, w); check("R7 short high run ignored", w, 0);

    // R8: restart after recovery begins at first ramp step
    bus_high = 1'b1;
    measure(NONE, NONE, w); check("R8 restart step 1", w, 4);
    measure(NONE, NONE, w); check("R8 restart step 2", w, 9);
    measure(NONE, NONE, w);
    measure(NONE, NONE, w); check("R8 restart full", w, MX);

    // R9: undervoltage kills gate in the same cycle
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk); #1;
      if (gate && !last_g) break;
      last_g = gate;
    end
    @(negedge clk); #1;
    check("R9 gate high before uvlo", int'(gate), 1);
    @(negedge clk);
    uvlo = 1'b1;
    #1 check("R9 same-cycle off", int'(gate), 0);
    last_g = 1'b0;
    measure(NONE, NONE, w); check("R9 held off", w, 0);
    uvlo = 1'b0;
    measure(NONE, NONE, w); check("R9 R8 ramp after uvlo", w, 4);

    summary();
    $finish;
  end

endmodule